// File: doc/BRIEF.md
# Rounding Right Shift Unit

This block divides a data word by a power of two. It shifts a word right by an amount from 1 to the full word width, and the amount is fixed for each operation. The caller chooses how the word is read: as two's-complement, which fills the vacated bits with the sign, or as unsigned, which fills them with zeros. When rounding is on, half of the last unit kept is added before the shift, so the result is the quotient rounded to nearest with ties going upward.

The addition can carry past the top bit of the word. The block keeps that carry by working on a sum two bits wider than the word. The result is therefore the exact rounded quotient in every mode, and this includes a shift by the full word width. An amount of zero, or an amount wider than the word, is refused. In that case an error flag is raised and the input word passes through unchanged. The result is combinational. A parameter can place it behind one output register.

Top module: `rshr_unit`

## Requirements
- R1: With rounding off and an amount of W-1 or less (W = DATA_W), the result is the input shifted right by that amount. In signed mode the vacated bits are filled with the sign bit. In unsigned mode they are filled with zeros.
- R2: In signed mode with rounding off and an amount of W, the result is all ones when bit W-1 of the input is set, and zero otherwise.
- R3: In unsigned mode with rounding off and an amount of W, the result is zero.
- R4: With rounding on and a legal amount n, the result equals floor((x + 2^(n-1)) / 2^n) computed with unbounded precision, then truncated to W bits. Here x is the input read as signed or as unsigned, according to the mode.
- R5: In signed mode with rounding on, a non-negative input whose rounding sum passes the sign bit gives a non-negative result. For example, 0x7FFF_FFFF_FFFF_FFFF shifted by 1 gives 0x4000_0000_0000_0000.
- R6: In signed mode with rounding on and an amount of W, the result is zero for every input.
- R7: In unsigned mode with rounding on, a carry out of the addition appears as bit W-n of the result. For example, all ones shifted by 4 gives 0x1000_0000_0000_0000.
- R8: In unsigned mode with rounding on and an amount of W, the result is 1 when the addition carries out of W bits, and 0 otherwise.
- R9: An amount of 0, or an amount above W, sets err_o to 1 and makes res_o equal the input. For any legal amount, err_o is 0.
- R10: With OUT_REG=1, res_o and err_o show the values for the inputs sampled at the previous rising clock edge. While rst_ni is low, both outputs are 0. With OUT_REG=0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Word to shift |
| sgn_i | input | 1 | 1: two's-complement input, 0: unsigned input |
| rnd_i | input | 1 | 1: add half of the last kept unit before shifting |
| shamt_i | input | $clog2(DATA_W)+1 | Shift amount; legal range is 1 to DATA_W |
| res_o | output | DATA_W | Shifted result, or the input when the amount is illegal |
| err_o | output | 1 | Illegal shift amount |

## Verification
The bench builds two copies of the block, both with DATA_W=64. One has OUT_REG=1 and is checked one clock after its inputs are driven. The other has OUT_REG=0 and is checked with its inputs held. With the full 64-bit width, a shift by 64 is reachable, and so are the carry out of the rounding sum at bit 64 and the signed overflow past bit 63. Every amount from 1 to 64 is swept in all four modes, and the amounts 0, 65 and 127 are driven to reach the illegal-amount path.

// File: rtl/rshr_pkg.sv
package rshr_pkg;

    localparam int unsigned RSHR_DEF_W = 64;

    typedef enum logic {
        EXT_ZERO = 1'b0,
        EXT_SIGN = 1'b1
    } ext_kind_e;

endpackage

// File: rtl/rshr_ctrl.sv
module rshr_ctrl #(
    parameter int unsigned W   = 64,
    parameter int unsigned SHW = $clog2(W) + 1,
    parameter int unsigned EW  = W + 2
) (
    input  logic [SHW-1:0] shamt_i,
    input  logic           rnd_i,
    output logic           legal_o,
    output logic [EW-1:0]  rconst_o
);
    localparam logic [SHW-1:0] MAX_AMT = SHW'(W);

    always_comb begin
        legal_o  = (shamt_i != '0) && (shamt_i <= MAX_AMT);
        rconst_o = '0;
        if (rnd_i && legal_o) begin
            rconst_o = EW'(1) << (shamt_i - SHW'(1));
        end
    end
endmodule

// File: rtl/rshr_add.sv
module rshr_add
    import rshr_pkg::*;
#(
    parameter int unsigned W  = 64,
    parameter int unsigned EW = W + 2
) (
    input  logic [W-1:0]  data_i,
    input  ext_kind_e     kind_i,
    input  logic [EW-1:0] rconst_i,
    output logic [EW-1:0] sum_o
);
    logic [EW-1:0] ext_w;

    always_comb begin
        if (kind_i == EXT_SIGN) begin
            ext_w = {{(EW-W){data_i[W-1]}}, data_i};
        end else begin
            ext_w = {{(EW-W){1'b0}}, data_i};
        end
        sum_o = ext_w + rconst_i;
    end
endmodule

// File: rtl/rshr_shift.sv
module rshr_shift #(
    parameter int unsigned W   = 64,
    parameter int unsigned SHW = $clog2(W) + 1,
    parameter int unsigned EW  = W + 2
) (
    input  logic [EW-1:0]  sum_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   res_o
);
    logic          fill_w;
    logic [EW-1:0] stage_w [0:SHW];

    assign fill_w     = sum_i[EW-1];
    assign stage_w[0] = sum_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int unsigned AMT = 1 << k;
        if (AMT >= EW) begin : g_full
            assign stage_w[k+1] = shamt_i[k] ? {EW{fill_w}} : stage_w[k];
        end else begin : g_part
            assign stage_w[k+1] = shamt_i[k]
                ? {{AMT{fill_w}}, stage_w[k][EW-1:AMT]}
                : stage_w[k];
        end
    end

    assign res_o = stage_w[SHW][W-1:0];
endmodule

// File: rtl/rshr_unit.sv
module rshr_unit
    import rshr_pkg::*;
#(
    parameter int unsigned DATA_W  = RSHR_DEF_W,
    parameter bit          OUT_REG = 1'b1,
    localparam int unsigned SHW    = $clog2(DATA_W) + 1,
    localparam int unsigned EW     = DATA_W + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] data_i,
    input  logic              sgn_i,
    input  logic              rnd_i,
    input  logic [SHW-1:0]    shamt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              err_o
);
    localparam logic [SHW-1:0] FULL_AMT = SHW'(DATA_W);

    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] res;
    } out_t;

    logic              legal_w;
    logic [EW-1:0]     rconst_w;
    logic [EW-1:0]     sum_w;
    logic [DATA_W-1:0] shifted_w;
    ext_kind_e         kind_w;
    out_t              out_d;
    out_t              out_q;

    assign kind_w = sgn_i ? EXT_SIGN : EXT_ZERO;

    rshr_ctrl #(.W(DATA_W), .SHW(SHW), .EW(EW)) u_ctrl (
        .shamt_i  (shamt_i),
        .rnd_i    (rnd_i),
        .legal_o  (legal_w),
        .rconst_o (rconst_w)
    );

    rshr_add #(.W(DATA_W), .EW(EW)) u_add (
        .data_i   (data_i),
        .kind_i   (kind_w),
        .rconst_i (rconst_w),
        .sum_o    (sum_w)
    );

    rshr_shift #(.W(DATA_W), .SHW(SHW), .EW(EW)) u_shift (
        .sum_i   (sum_w),
        .shamt_i (shamt_i),
        .res_o   (shifted_w)
    );

    always_comb begin
        out_d.err = !legal_w;
        out_d.res = legal_w ? shifted_w : data_i;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        // R10: registered output lags the computed value by one clock
        assert_reg_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rst_ni |=> (out_q == $past(out_d)));
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign res_o = out_q.res;
    assign err_o = out_q.err;

    // R9: illegal amount passes the input through and flags it
    assert_illegal_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((shamt_i == '0) || (shamt_i > FULL_AMT)) |-> (out_d.err && out_d.res == data_i));

    // R2: signed full-width shift without rounding gives sign fill
    assert_sgn_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sgn_i && !rnd_i && shamt_i == FULL_AMT) |-> (out_d.res == {DATA_W{data_i[DATA_W-1]}}));

    // R3: unsigned full-width shift without rounding gives zero
    assert_uns_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sgn_i && !rnd_i && shamt_i == FULL_AMT) |-> (out_d.res == '0));

    // R6: signed rounded full-width shift gives zero
    assert_sgn_rnd_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sgn_i && rnd_i && shamt_i == FULL_AMT) |-> (out_d.res == '0));

    // R8: unsigned rounded full-width shift yields only the carry bit
    assert_uns_rnd_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sgn_i && rnd_i && shamt_i == FULL_AMT) |-> (out_d.res[DATA_W-1:1] == '0));
endmodule

// File: tb/sim_rshr_unit.sv
module sim_rshr_unit;
    localparam int CLK_P = 10;
    localparam int W     = 64;
    localparam int SHW   = $clog2(W) + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   data = '0;
    logic           sgn = 1'b0;
    logic           rnd = 1'b0;
    logic [SHW-1:0] shamt = '0;
    logic [W-1:0]   res_r, res_c;
    logic           err_r, err_c;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    rshr_unit #(.DATA_W(W), .OUT_REG(1'b1)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .data_i(data), .sgn_i(sgn), .rnd_i(rnd),
        .shamt_i(shamt), .res_o(res_r), .err_o(err_r)
    );

    rshr_unit #(.DATA_W(W), .OUT_REG(1'b0)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .data_i(data), .sgn_i(sgn), .rnd_i(rnd),
        .shamt_i(shamt), .res_o(res_c), .err_o(err_c)
    );

    function automatic logic [W-1:0] ref_shr(logic [W-1:0] x, bit s, bit r, int n);
        logic [127:0] e;
        if (n < 1 || n > W) return x;
        e = s ? {{(128-W){x[W-1]}}, x} : {{(128-W){1'b0}}, x};
        if (r) e = e + (128'd1 << (n - 1));
        e = $signed(e) >>> n;
        return e[W-1:0];
    endfunction

    task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive, let the register capture, then compare both copies
    task automatic run(string tag, logic [W-1:0] x, bit s, bit r, int n, logic [W-1:0] exp);
        @(negedge clk);
        data = x; sgn = s; rnd = r; shamt = SHW'(n);
        @(posedge clk);
        #1;
        chk({tag, " reg"}, res_r, exp);
        chk({tag, " comb"}, res_c, exp);
        chk({tag, " err R9"}, {{(W-1){1'b0}}, err_r}, {{(W-1){1'b0}}, (n < 1 || n > W)});
    endtask

    function automatic string tag_of(bit s, bit r, int n);
        if (n < 1 || n > W) return "R9";
        if (!r) return (n == W) ? (s ? "R2" : "R3") : "R1";
        if (n == W) return s ? "R6" : "R8";
        return s ? "R4/R5" : "R4/R7";
    endfunction

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5A17);
        data = 64'hDEAD_BEEF_0123_4567; sgn = 1'b1; rnd = 1'b1; shamt = 7'd3;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset res", res_r, '0);
        chk("R10 reset err", {{(W-1){1'b0}}, err_r}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        run("R1 sgn", 64'h8000_0000_0000_0000, 1, 0, 4, 64'hF800_0000_0000_0000);
        run("R1 uns", 64'h8000_0000_0000_0000, 0, 0, 4, 64'h0800_0000_0000_0000);
        run("R1 sgn63", 64'h8000_0000_0000_0000, 1, 0, 63, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R2 neg", 64'h8000_0000_0000_0001, 1, 0, 64, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R2 pos", 64'h7FFF_FFFF_FFFF_FFFF, 1, 0, 64, 64'h0);
        run("R3", 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 64, 64'h0);
        run("R4 tie", 64'h0000_0000_0000_0006, 0, 1, 2, 64'h2);
        run("R4 neg", 64'hFFFF_FFFF_FFFF_FFFA, 1, 1, 2, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R5", 64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 1, 64'h4000_0000_0000_0000);
        run("R5 s8", 64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 8, 64'h0080_0000_0000_0000);
        run("R6 neg", 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 64, 64'h0);
        run("R6 pos", 64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 64, 64'h0);
        run("R7", 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 4, 64'h1000_0000_0000_0000);
        run("R7 s1", 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1, 64'h8000_0000_0000_0000);
        run("R8 carry", 64'h8000_0000_0000_0000, 0, 1, 64, 64'h1);
        run("R8 none", 64'h7FFF_FFFF_FFFF_FFFF, 0, 1, 64, 64'h0);
        run("R9 zero", 64'h0123_4567_89AB_CDEF, 1, 1, 0, 64'h0123_4567_89AB_CDEF);
        run("R9 65", 64'hFEDC_BA98_7654_3210, 0, 0, 65, 64'hFEDC_BA98_7654_3210);
        run("R9 127", 64'h5555_AAAA_5555_AAAA, 1, 0, 127, 64'h5555_AAAA_5555_AAAA);

        for (int m = 0; m < 4; m++) begin
            for (int n = 1; n <= W; n++) begin
                logic [W-1:0] x;
                x = {$urandom(), $urandom()};
                run(tag_of(m[0], m[1], n), x, m[0], m[1], n, ref_shr(x, m[0], m[1], n));
            end
        end

        for (int i = 0; i < 1500; i++) begin
            logic [W-1:0] x;
            bit s, r;
            int n;
            x = {$urandom(), $urandom()};
            if (i % 7 == 0) x = {x[W-1], {(W-1){~x[W-1]}}};
            s = $urandom() % 2;
            r = $urandom() % 2;
            n = (i % 50 == 0) ? ($urandom() % 128) : (1 + $urandom() % W);
            run(tag_of(s, r, n), x, s, r, n, ref_shr(x, s, r, n));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule